// File: doc/BRIEF.md
# Planar Frame Buffer Address Mapper

This block sits between a host bus and a four-plane video frame buffer. For each host access it checks whether the address falls inside the legacy planar video window that is currently selected. If it does, the block emits one frame buffer access per byte. Each access carries a DWORD index and, for writes, a 4-bit plane enable. Each host byte address selects one 32-bit word that spans all four planes.

The write mapping is chosen by a control input:
- In the plain mapping, the plane mask passes straight through as the enables.
- In the odd/even mapping, the low address bit picks a pair of planes, and the page bit replaces bit 0 of the index.
- In the chain-4 mapping, the two low address bits pick a single plane, and the two low index bits are cleared.

In both rewriting mappings the address-derived enables are gated by the plane mask.

A host access of two or four bytes is issued as a run of single-byte accesses to consecutive addresses, one per clock. The block reports busy while the later bytes of a run are still going out. Register programming, the memory array and the data path live elsewhere.

Top module: `planar_addr_mapper`

## Requirements
- R1: While reset is held and in the first cycle after it, `fb_valid`, `fb_write`, `fb_en` and `busy` are all 0.
- R2: `map_sel` picks the window: 0 is A0000h–BFFFFh, 1 is A0000h–AFFFFh, 2 is B0000h–B7FFFh, and 3 is B8000h–BFFFFh. A byte outside the window gives `fb_valid`=0, `fb_write`=0, `fb_en`=0 and `fb_addr`=0.
- R3: A byte accepted at a clock edge appears on the outputs right after that edge. On a hit, the index starts from host address bits [15:0].
- R4: With `wmap`=0 (plain mapping), a write hit gives `fb_en` = `map_mask` and `fb_addr` = address[15:0].
- R5: With `wmap`=1 (odd/even), a write hit enables planes 0 and 2 when address bit 0 is 0, or planes 1 and 3 when it is 1, ANDed with `map_mask`. In this mapping `fb_addr` is {address[15:1], `page_bit`}.
- R6: With `wmap`=2 (chain-4), a write hit enables only plane address[1:0], ANDed with `map_mask`. In this mapping `fb_addr` is {address[15:2], 2'b00}.
- R7: `wmap`=3 behaves exactly as the plain mapping.
- R8: `req_size` gives the access width: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. Byte i of an access is presented i cycles after byte 0, at host address + i, and each byte is mapped and window-checked on its own.
- R9: `busy` is 1 in every cycle of a run except the one presenting its last byte. A request offered while `busy` is 1 is dropped and produces no access.
- R10: A read hit gives `fb_write`=0, `fb_en`=0 and `fb_addr` = address[15:0], whatever the write mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access offered this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host byte address of the first byte |
| req_size | input | 2 | Access width code |
| map_sel | input | 2 | Window selection |
| wmap | input | 2 | Write mapping selection |
| map_mask | input | 4 | Plane mask register value |
| page_bit | input | 1 | Page bit used by odd/even mapping |
| busy | output | 1 | Later bytes of a run still being issued |
| fb_valid | output | 1 | Frame buffer access this cycle |
| fb_write | output | 1 | Frame buffer access is a write |
| fb_addr | output | IDX_W | DWORD index into the frame buffer |
| fb_en | output | 4 | Plane write enables |

## Verification
The assertions assume that `wmap`, `map_mask` and `page_bit` come from registers. They compare the outputs against the control values of the cycle before, when the byte was mapped, so those inputs must not change while a run is in flight. The stimulus changes the configuration only between accesses, never while `busy` is high. Random addresses cluster around the window edges, so that runs cross from a hit into a miss. Requests offered during a run are driven on purpose to confirm that they are dropped.

// File: rtl/planar_addr_mapper.sv
module planar_addr_mapper #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [1:0]        map_sel,
  input  logic [1:0]        wmap,
  input  logic [3:0]        map_mask,
  input  logic              page_bit,
  output logic              busy,
  output logic              fb_valid,
  output logic              fb_write,
  output logic [IDX_W-1:0]  fb_addr,
  output logic [3:0]        fb_en
);

  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        rem;
  logic              cur_write;
  logic [1:0]        extra;
  logic              hit;
  logic [3:0]        en_n;
  logic [IDX_W-1:0]  idx_n;

  assign busy = (rem != 2'd0);

  wire              accept    = req_valid && !busy;
  wire [ADDR_W-1:0] iss_addr  = accept ? req_addr : cur_addr;
  wire              iss_write = accept ? req_write : cur_write;
  wire              iss_valid = accept || busy;

  always_comb begin
    case (req_size)
      2'd0:    extra = 2'd0;
      2'd1:    extra = 2'd1;
      default: extra = 2'd3;
    endcase
  end

  always_comb begin
    case (map_sel)
      2'd0:    hit = (iss_addr >> 17) == ADDR_W'(5);
      2'd1:    hit = (iss_addr >> 16) == ADDR_W'(10);
      2'd2:    hit = (iss_addr >> 15) == ADDR_W'(22);
      default: hit = (iss_addr >> 15) == ADDR_W'(23);
    endcase
  end

  always_comb begin
    en_n  = map_mask;
    idx_n = iss_addr[IDX_W-1:0];
    if (!iss_write) begin
      en_n = 4'b0000;
    end else begin
      case (wmap)
        2'd1: begin
          en_n  = (iss_addr[0] ? 4'b1010 : 4'b0101) & map_mask;
          idx_n = {iss_addr[IDX_W-1:1], page_bit};
        end
        2'd2: begin
          en_n  = (4'b0001 << iss_addr[1:0]) & map_mask;
          idx_n = {iss_addr[IDX_W-1:2], 2'b00};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem       <= '0;
      cur_addr  <= '0;
      cur_write <= 1'b0;
      fb_valid  <= 1'b0;
      fb_write  <= 1'b0;
      fb_en     <= '0;
      fb_addr   <= '0;
    end else begin
      if (accept) begin
        rem       <= extra;
        cur_addr  <= req_addr + ADDR_W'(1);
        cur_write <= req_write;
      end else if (busy) begin
        rem      <= rem - 2'd1;
        cur_addr <= cur_addr + ADDR_W'(1);
      end
      fb_valid <= iss_valid && hit;
      fb_write <= iss_valid && hit && iss_write;
      fb_en    <= (iss_valid && hit) ? en_n : 4'b0000;
      fb_addr  <= (iss_valid && hit) ? idx_n : '0;
    end
  end

endmodule

module planar_addr_mapper_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       wmap,
  input logic [3:0]       map_mask,
  input logic             page_bit,
  input logic             busy,
  input logic             fb_valid,
  input logic             fb_write,
  input logic [IDX_W-1:0] fb_addr,
  input logic [3:0]       fb_en
);

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_valid |-> (fb_en == 4'b0000 && !fb_write));

  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && fb_write) |-> ((fb_en & ~$past(map_mask)) == 4'b0000));

  // R5
  oddeven_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && fb_write && $past(wmap) == 2'd1) |->
      (fb_addr[0] == $past(page_bit) &&
       ((fb_en & 4'b1010) == 4'b0000 || (fb_en & 4'b0101) == 4'b0000)));

  // R6
  chain4_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && fb_write && $past(wmap) == 2'd2) |->
      ($onehot0(fb_en) && fb_addr[1:0] == 2'b00));

  // R10
  read_noen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && !fb_write) |-> fb_en == 4'b0000);

  // R9
  busy_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(busy, 2)) |=> !busy);

endmodule

bind planar_addr_mapper planar_addr_mapper_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wmap(wmap), .map_mask(map_mask),
  .page_bit(page_bit), .busy(busy), .fb_valid(fb_valid),
  .fb_write(fb_write), .fb_addr(fb_addr), .fb_en(fb_en)
);

// File: tb/sim_planar_addr_mapper.sv
module sim_planar_addr_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  map_sel = '0;
  logic [1:0]  wmap = '0;
  logic [3:0]  map_mask = '0;
  logic        page_bit = 1'b0;
  logic        busy, fb_valid, fb_write;
  logic [15:0] fb_addr;
  logic [3:0]  fb_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  planar_addr_mapper u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .map_sel(map_sel), .wmap(wmap),
    .map_mask(map_mask), .page_bit(page_bit), .busy(busy), .fb_valid(fb_valid),
    .fb_write(fb_write), .fb_addr(fb_addr), .fb_en(fb_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] model(input logic [31:0] a, input logic w,
      input logic [1:0] ms, input logic [1:0] wm, input logic [3:0] mk, input logic pb);
    logic h;
    logic [3:0] en;
    logic [15:0] ix;
    case (ms)
      2'd0:    h = (a >= 32'hA0000 && a <= 32'hBFFFF);
      2'd1:    h = (a >= 32'hA0000 && a <= 32'hAFFFF);
      2'd2:    h = (a >= 32'hB0000 && a <= 32'hB7FFF);
      default: h = (a >= 32'hB8000 && a <= 32'hBFFFF);
    endcase
    if (!h) return '0;
    if (!w) return {1'b1, 1'b0, 4'b0000, a[15:0]};
    en = mk;
    ix = a[15:0];
    if (wm == 2'd1) begin
      en = (a[0] ? 4'b1010 : 4'b0101) & mk;
      ix = {a[15:1], pb};
    end else if (wm == 2'd2) begin
      en = 4'b0000;
      en[a[1:0]] = mk[a[1:0]];
      ix = {a[15:2], 2'b00};
    end
    return {1'b1, 1'b1, en, ix};
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic w,
      input logic [1:0] ms, input logic [1:0] wm, input logic [3:0] mk,
      input logic pb, input bit inject);
    int n;
    logic [21:0] e;
    string tag;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w;
    map_sel = ms; wmap = wm; map_mask = mk; page_bit = pb;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (inject && n == 4) begin
          req_addr = 32'hA0010; req_size = 2'd0; req_write = 1'b1;
        end else begin
          req_valid = 1'b0;
        end
      end else if (i == 1) begin
        req_valid = 1'b0;
      end
      e = model(a + i, w, ms, wm, mk, pb);
      if (!e[21]) tag = "R2";
      else if (!w) tag = "R10";
      else if (n > 1) tag = "R8";
      else if (wm == 2'd1) tag = "R5";
      else if (wm == 2'd2) tag = "R6";
      else if (wm == 2'd3) tag = "R7";
      else tag = "R4";
      chk(tag, {10'd0, fb_valid, fb_write, fb_en, fb_addr}, {10'd0, e});
      if (i == 0 && e[21]) chk("R3", {31'd0, fb_valid}, 32'd1);
      chk("R9", {31'd0, busy}, {31'd0, (i < n - 1)});
    end
    @(negedge clk);
    chk("R9", {30'd0, fb_valid, busy}, 32'd0);
  endtask

  initial begin
    logic [31:0] bases [6];
    bases[0] = 32'hA0000; bases[1] = 32'hB0000; bases[2] = 32'hB8000;
    bases[3] = 32'hAFFF0; bases[4] = 32'h9FFF8; bases[5] = 32'hBFFF8;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1", {29'd0, fb_valid, fb_write, busy}, 32'd0);
    chk("R1", {28'd0, fb_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'd0, fb_valid, fb_write, busy, |fb_en}, 32'd0);

    access(32'hA1234, 2'd0, 1'b1, 2'd0, 2'd0, 4'hF, 1'b0, 1'b0); // R3 R4
    access(32'hA0001, 2'd0, 1'b1, 2'd1, 2'd1, 4'hF, 1'b1, 1'b0); // R5
    access(32'hA0000, 2'd0, 1'b1, 2'd1, 2'd1, 4'h7, 1'b0, 1'b0); // R5
    access(32'hB8007, 2'd0, 1'b1, 2'd3, 2'd2, 4'hF, 1'b0, 1'b0); // R6
    access(32'hB8006, 2'd0, 1'b1, 2'd3, 2'd2, 4'hB, 1'b0, 1'b0); // R6 masked off
    access(32'hA5555, 2'd0, 1'b1, 2'd0, 2'd3, 4'h9, 1'b1, 1'b0); // R7
    access(32'hB0000, 2'd0, 1'b1, 2'd1, 2'd0, 4'hF, 1'b0, 1'b0); // R2 miss
    access(32'hC0000, 2'd0, 1'b1, 2'd0, 2'd0, 4'hF, 1'b0, 1'b0); // R2 miss
    access(32'hAFFFF, 2'd1, 1'b1, 2'd1, 2'd0, 4'hF, 1'b0, 1'b0); // R8 crosses out
    access(32'hB7FFE, 2'd2, 1'b1, 2'd2, 2'd2, 4'hF, 1'b0, 1'b0); // R8 crosses out
    access(32'hA0000, 2'd1, 1'b1, 2'd0, 2'd0, 4'hF, 1'b0, 1'b0); // R8 word
    access(32'hA0100, 2'd3, 1'b1, 2'd0, 2'd1, 4'hF, 1'b1, 1'b1); // R9 injected
    access(32'hB8003, 2'd0, 1'b0, 2'd3, 2'd2, 4'hF, 1'b1, 1'b0); // R10

    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      int b;
      b = int'($urandom % 7);
      if (b == 6) a = $urandom;
      else a = bases[b] + ($urandom % 32'h10);
      if ($urandom % 3 == 0 && b < 3) a = bases[b] + ($urandom % 32'h10000);
      access(a, 2'($urandom), 1'($urandom % 4 != 0), 2'($urandom), 2'($urandom),
             4'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule